// File: doc/BRIEF.md
# Host/Network Ready-Line Supervisor

This block looks after link readiness between a host adapter and the network processor at the far end of a serial line. Software uses single-cycle strobes to raise or drop the host's own ready bit. The block watches the far end's ready input, which is asynchronous. When that input falls, a sticky line-error flag is set. A transfer-enable output tells the transmitter and receiver whether data may move at all.

The error flag stays set until software clears it, and a clear is accepted only when the far end is ready again. While the flag is set, transfer-enable stays low even after the far end recovers. A status-request strobe captures a snapshot of the line states into an output word. Every change of the synchronized far-end state produces a one-cycle event pulse that the reporting logic can use.

Top module: `ready_line_supervisor`

## Requirements
- R1: After reset, host_rdy_o, line_err_o, xfer_en_o, peer_evt_o and stat_vld_o are 0 and stat_word_o is all zeros.
- R2: cmd_host_set sets host_rdy_o at the next clock edge and cmd_host_clr clears it there. When both strobes arrive together, the clear wins.
- R3: peer_rdy_i passes through SYNC_STAGES flops (default 2) before use. A change on it therefore reaches xfer_en_o and the status snapshot after SYNC_STAGES clock edges.
- R4: A 1-to-0 change of the synchronized far-end level sets line_err_o at the following edge. With the defaults, that is three edges after the input change.
- R5: line_err_o stays set when the far end becomes ready again, as long as no accepted clear arrives.
- R6: cmd_err_clr clears line_err_o at the next edge only when the synchronized far-end level is 1 at that edge. Otherwise the strobe has no effect. A far-end drop seen at the same edge as a clear leaves the flag set.
- R7: xfer_en_o is 1 exactly when host_rdy_o is 1, the synchronized far-end level is 1 and line_err_o is 0.
- R8: At the edge where cmd_stat_req is sampled high, stat_word_o is loaded as follows: bit 0 takes host-ready, bit 1 the synchronized far-end level and bit 2 the error flag, each as held just before that edge, and the upper bits are 0. stat_vld_o is high for the single following cycle. Without a request, stat_word_o holds its value.
- R9: peer_evt_o pulses high for one cycle for each change of the synchronized far-end level, rising or falling. The pulse comes at the same edge at which a drop sets the error flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_host_set | input | 1 | Strobe: raise host ready |
| cmd_host_clr | input | 1 | Strobe: drop host ready |
| cmd_err_clr | input | 1 | Strobe: request clearing of the line error |
| cmd_stat_req | input | 1 | Strobe: capture a status snapshot |
| peer_rdy_i | input | 1 | Far-end ready line, asynchronous |
| host_rdy_o | output | 1 | Host ready bit |
| line_err_o | output | 1 | Sticky ready-line error flag |
| xfer_en_o | output | 1 | Data transfer permitted |
| peer_evt_o | output | 1 | One-cycle far-end state change event |
| stat_word_o | output | STAT_W | Status snapshot word |
| stat_vld_o | output | 1 | Snapshot updated in this cycle |

## Verification
The bench first clears the error while the far end is still down. A design that ignored the level check would drop the flag there and turn transfer-enable back on over a dead line. It then lets the far end recover with the flag still set. A non-sticky flag, or a transfer gate without the error term, would turn transfer-enable back on early. It checks both strobes together, where a wrong priority would leave host-ready set. It also checks the exact edge at which a snapshot captures values and at which the event appears, which exposes a wrong synchronizer depth or a snapshot taken from post-edge values.

// File: rtl/rls_pkg.sv
package rls_pkg;
    localparam int ST_HOST_BIT = 0;
    localparam int ST_PEER_BIT = 1;
    localparam int ST_ERR_BIT  = 2;
    localparam int ST_USED     = 3;

    typedef struct packed {
        logic host;
        logic err;
        logic evt;
    } ctrl_state_t;
endpackage

// File: rtl/rls_sync.sv
module rls_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic lvl_o,
    output logic rise_o,
    output logic fall_o
);
    localparam int LAST = STAGES - 1;

    // bits [STAGES-1:0] form the chain, bit STAGES holds the previous level
    logic [STAGES:0] shift_d, shift_q;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                assign shift_d[0] = async_i;
            end else begin : g_next
                assign shift_d[i] = shift_q[i-1];
            end
        end
    endgenerate
    assign shift_d[STAGES] = shift_q[LAST];

    always_ff @(posedge clk) begin
        if (!rst_n) shift_q <= '0;
        else        shift_q <= shift_d;
    end

    assign lvl_o  = shift_q[LAST];
    assign rise_o = shift_q[LAST] & ~shift_q[STAGES];
    assign fall_o = ~shift_q[LAST] & shift_q[STAGES];
endmodule

// File: rtl/rls_ctrl.sv
module rls_ctrl
    import rls_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cmd_host_set,
    input  logic cmd_host_clr,
    input  logic cmd_err_clr,
    input  logic peer_lvl,
    input  logic peer_rise,
    input  logic peer_fall,
    output logic host_rdy,
    output logic line_err,
    output logic peer_evt,
    output logic xfer_en
);
    ctrl_state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.evt = peer_rise | peer_fall;
        if (cmd_host_set) st_d.host = 1'b1;
        if (cmd_host_clr) st_d.host = 1'b0;
        if (cmd_err_clr && peer_lvl) st_d.err = 1'b0;
        if (peer_fall) st_d.err = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign host_rdy = st_q.host;
    assign line_err = st_q.err;
    assign peer_evt = st_q.evt;
    assign xfer_en  = st_q.host & peer_lvl & ~st_q.err;

    p_host_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_host_set && !cmd_host_clr) |=> host_rdy);
    p_host_clr_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_host_clr |=> !host_rdy);
    p_err_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
        peer_fall |=> line_err);
    p_err_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (line_err && !(cmd_err_clr && peer_lvl)) |=> line_err);
    p_clr_needs_peer_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (line_err && cmd_err_clr && !peer_lvl) |=> line_err);
endmodule

// File: rtl/rls_snap.sv
module rls_snap
    import rls_pkg::*;
#(
    parameter int STAT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              host_rdy,
    input  logic              peer_lvl,
    input  logic              line_err,
    output logic [STAT_W-1:0] word_o,
    output logic              vld_o
);
    logic [STAT_W-1:0] word_d, word_q;
    logic              vld_d, vld_q;

    always_comb begin
        word_d = word_q;
        vld_d  = req;
        if (req) begin
            word_d              = '0;
            word_d[ST_HOST_BIT] = host_rdy;
            word_d[ST_PEER_BIT] = peer_lvl;
            word_d[ST_ERR_BIT]  = line_err;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q <= '0;
            vld_q  <= 1'b0;
        end else begin
            word_q <= word_d;
            vld_q  <= vld_d;
        end
    end

    assign word_o = word_q;
    assign vld_o  = vld_q;

    p_stat_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !req |=> $stable(word_o));
    p_vld_follows_r8: assert property (@(posedge clk) disable iff (!rst_n)
        req |=> vld_o);
endmodule

// File: rtl/ready_line_supervisor.sv
module ready_line_supervisor
    import rls_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int STAT_W      = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_host_set,
    input  logic              cmd_host_clr,
    input  logic              cmd_err_clr,
    input  logic              cmd_stat_req,
    input  logic              peer_rdy_i,
    output logic              host_rdy_o,
    output logic              line_err_o,
    output logic              xfer_en_o,
    output logic              peer_evt_o,
    output logic [STAT_W-1:0] stat_word_o,
    output logic              stat_vld_o
);
    logic peer_lvl, peer_rise, peer_fall;

    rls_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .async_i(peer_rdy_i),
        .lvl_o  (peer_lvl),
        .rise_o (peer_rise),
        .fall_o (peer_fall)
    );

    rls_ctrl u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd_host_set(cmd_host_set),
        .cmd_host_clr(cmd_host_clr),
        .cmd_err_clr (cmd_err_clr),
        .peer_lvl    (peer_lvl),
        .peer_rise   (peer_rise),
        .peer_fall   (peer_fall),
        .host_rdy    (host_rdy_o),
        .line_err    (line_err_o),
        .peer_evt    (peer_evt_o),
        .xfer_en     (xfer_en_o)
    );

    rls_snap #(.STAT_W(STAT_W)) u_snap (
        .clk     (clk),
        .rst_n   (rst_n),
        .req     (cmd_stat_req),
        .host_rdy(host_rdy_o),
        .peer_lvl(peer_lvl),
        .line_err(line_err_o),
        .word_o  (stat_word_o),
        .vld_o   (stat_vld_o)
    );

    p_xfer_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (line_err_o || !host_rdy_o) |-> !xfer_en_o);
endmodule

// File: tb/ready_line_supervisor_test.sv
`timescale 1ns/1ps
module ready_line_supervisor_test;
    localparam int STAT_W = 8;
    localparam int NVEC   = 20;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmd_host_set = 1'b0, cmd_host_clr = 1'b0, cmd_err_clr = 1'b0;
    logic cmd_stat_req = 1'b0, peer_rdy_i = 1'b0;
    logic host_rdy_o, line_err_o, xfer_en_o, peer_evt_o, stat_vld_o;
    logic [STAT_W-1:0] stat_word_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    ready_line_supervisor #(.SYNC_STAGES(2), .STAT_W(STAT_W)) uut (
        .clk(clk), .rst_n(rst_n),
        .cmd_host_set(cmd_host_set), .cmd_host_clr(cmd_host_clr),
        .cmd_err_clr(cmd_err_clr), .cmd_stat_req(cmd_stat_req),
        .peer_rdy_i(peer_rdy_i),
        .host_rdy_o(host_rdy_o), .line_err_o(line_err_o),
        .xfer_en_o(xfer_en_o), .peer_evt_o(peer_evt_o),
        .stat_word_o(stat_word_o), .stat_vld_o(stat_vld_o)
    );

    // inputs {set, hclr, eclr, sreq, peer} ; expected {host, xfer, err, evt, vld, status[2:0]}
    localparam logic [12:0] VEC [NVEC] = '{
        {5'b10000, 8'b10000000},  // R2 set
        {5'b00001, 8'b10000000},  // R3 first sync stage only
        {5'b00011, 8'b11001001},  // R3 level through, R8 pre-edge snapshot
        {5'b00001, 8'b11010001},  // R9 rise event
        {5'b00011, 8'b11001011},  // R8 snapshot peer
        {5'b00000, 8'b11000011},  // R3 drop not yet visible
        {5'b00000, 8'b10000011},  // R7 peer low gates
        {5'b00000, 8'b10110011},  // R4 error latched, R9 fall event
        {5'b00100, 8'b10100011},  // R6 clear refused, far end down
        {5'b00001, 8'b10100011},
        {5'b00001, 8'b10100011},  // R5 sticky, R7 blocked
        {5'b00001, 8'b10110011},  // R9 rise event, still R5
        {5'b00011, 8'b10101111},  // R8 snapshot with error
        {5'b00101, 8'b11000111},  // R6 clear accepted
        {5'b01001, 8'b00000111},  // R2 reset host
        {5'b11001, 8'b00000111},  // R2 both strobes: clear wins
        {5'b10001, 8'b11000111},  // R2 set again
        {5'b00000, 8'b11000111},
        {5'b00000, 8'b10000111},
        {5'b00100, 8'b10110111}   // R6 clear with drop: flag set
    };

    task automatic chk(input logic [STAT_W-1:0] act, input logic [STAT_W-1:0] exp,
                       input string req, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic check_reset_state(input string tag);
        chk({7'b0, host_rdy_o}, 8'd0, "R1", {tag, " host"});
        chk({7'b0, line_err_o}, 8'd0, "R1", {tag, " err"});
        chk({7'b0, xfer_en_o},  8'd0, "R1", {tag, " xfer"});
        chk({7'b0, peer_evt_o}, 8'd0, "R1", {tag, " evt"});
        chk({7'b0, stat_vld_o}, 8'd0, "R1", {tag, " vld"});
        chk(stat_word_o,        8'd0, "R1", {tag, " word"});
    endtask

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        summary();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check_reset_state("initial");
        @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < NVEC; i++) begin
            {cmd_host_set, cmd_host_clr, cmd_err_clr, cmd_stat_req, peer_rdy_i} = VEC[i][12:8];
            @(posedge clk);
            #1;
            chk({7'b0, host_rdy_o}, {7'b0, VEC[i][7]}, "R2", $sformatf("row %0d host", i));
            chk({7'b0, xfer_en_o},  {7'b0, VEC[i][6]}, "R3/R7", $sformatf("row %0d xfer", i));
            chk({7'b0, line_err_o}, {7'b0, VEC[i][5]}, "R4/R5/R6", $sformatf("row %0d err", i));
            chk({7'b0, peer_evt_o}, {7'b0, VEC[i][4]}, "R9", $sformatf("row %0d evt", i));
            chk({7'b0, stat_vld_o}, {7'b0, VEC[i][3]}, "R8", $sformatf("row %0d vld", i));
            chk(stat_word_o, {5'b0, VEC[i][2:0]}, "R8", $sformatf("row %0d word", i));
            @(negedge clk);
        end
        {cmd_host_set, cmd_host_clr, cmd_err_clr, cmd_stat_req, peer_rdy_i} = 5'b00000;
        // R1: reset in the middle of operation, error flag and host bit set
        rst_n = 1'b0;
        @(posedge clk);
        #1;
        check_reset_state("midrun");
        @(negedge clk);
        rst_n = 1'b1;
        // R7: far end ready but host bit low keeps transfers off
        peer_rdy_i = 1'b1;
        repeat (4) @(posedge clk);
        #1;
        chk({7'b0, xfer_en_o}, 8'd0, "R7", "peer ready host low");
        summary();
    end
endmodule